// File: doc/BRIEF.md
# Flash Erase Status Sequencer

This block times the embedded operations of a parallel flash that uses an unlock-style command set, and it keeps the status byte that software polls while those operations run. The command decoder next to it sends one-cycle strobes: program start (with bit 7 of the data being programmed), sector erase, chip erase, erase suspend, erase resume, any other write, and status read. In return the block presents the status byte, a busy flag, a suspended flag, a per-read flag that says whether the read returns status or array data, and a one-cycle completion pulse. The pulse tells the decoder to go back to bypass mode or to read-array mode.

All durations are counted in clock ticks. The tick counts are worked out from a ticks-per-microsecond parameter and from power-of-two exponents for program time, per-sector erase time and chip erase time. Sector erase commands collect during an acceptance window. The erase then runs for one per-sector time for each queued command. A sector erase can be suspended and resumed without losing the time it has already spent. The block does not change the array contents.

The controller is a single state machine with six states:
- `ST_IDLE`: no operation in progress.
- `ST_PROG`: a program is running.
- `ST_WIN`: the sector acceptance window is open.
- `ST_ERASE`: a sector erase is running.
- `ST_CHIP`: a chip erase is running.
- `ST_SUSP`: a sector erase is suspended.

Transitions:
- `ST_IDLE` goes to `ST_PROG` on a program start.
- `ST_IDLE` goes to `ST_WIN` on a sector erase.
- `ST_IDLE` goes to `ST_CHIP` on a chip erase.
- `ST_WIN` stays in `ST_WIN` when another sector erase arrives.
- `ST_WIN` goes to `ST_ERASE` when the window expires.
- `ST_WIN` goes to `ST_SUSP` on a suspend.
- `ST_WIN` goes to `ST_IDLE` on an abort.
- `ST_ERASE` goes to `ST_SUSP` on a suspend.
- `ST_SUSP` goes to `ST_ERASE` on a resume.
- `ST_PROG`, `ST_ERASE` and `ST_CHIP` go to `ST_IDLE` when their timer expires.

Top module: `erase_status_timer`

## Requirements
- R1: After reset the status byte is 0x00, `busy_o`, `susp_o` and `done_o` are 0, and nothing is queued for erase.
- R2: A program start in idle sets status bit 7 to the inverse of `prog_d7`. `busy_o` then stays high for 2^PROG_EXP microseconds of ticks. When that time ends, bit 7 inverts, `done_o` pulses for one cycle and the block returns to idle.
- R3: Each status read during a program, the window, a sector erase or a chip erase toggles status bit 6 and asserts `rd_status_o`. During the three erase states it also toggles status bit 2. During a program, bit 2 does not change.
- R4: A sector erase in idle clears status bits 7 and 3 and opens a window of WIN_US microseconds. Inside the window, a further sector erase queues its sector, counts one more command and restarts the window. A program, chip erase, resume or other write inside the window empties the queue, stops the timer and returns to idle with no completion pulse.
- R5: When the window expires, status bit 3 is set and the erase runs for (queued commands) × 2^SECT_EXP milliseconds. During that time every strobe except suspend and read is ignored.
- R6: A chip erase in idle clears status bit 7 and runs for 2^CHIP_EXP milliseconds. During that time every strobe except read is ignored, including suspend.
- R7: A suspend inside the window saves the full erase time for the queued commands, clears status bit 3, stops the timer and raises `susp_o`.
- R8: A suspend during a running sector erase saves the remaining tick count, with a minimum of 1, clears status bit 3 and stops the timer.
- R9: While suspended, a read whose `rd_idx` names a queued sector asserts `rd_status_o` and toggles bit 2 but not bit 6. A read of any other sector leaves `rd_status_o` low and the status byte unchanged.
- R10: A resume while suspended sets status bit 3, clears bit 7 and runs the erase for exactly the saved tick count.
- R11: On completion of a sector erase, status bit 7 inverts, bit 3 clears and the sector queue and its count are emptied. Every completion gives a one-cycle `done_o`, with `to_bypass_o` equal to `bypass_i` at that edge.
- R12: A resume that arrives while not suspended has no effect. A suspend that arrives in idle, during a program or during a chip erase also has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_go | input | 1 | Program start strobe |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| sect_go | input | 1 | Sector erase command strobe |
| sect_idx | input | clog2(NUM_SECT) | Sector addressed by the erase command |
| chip_go | input | 1 | Chip erase start strobe |
| susp_go | input | 1 | Erase suspend strobe |
| resume_go | input | 1 | Erase resume strobe |
| other_wr | input | 1 | Any other write, which aborts the window |
| rd_go | input | 1 | Read strobe |
| rd_idx | input | clog2(NUM_SECT) | Sector addressed by the read |
| bypass_i | input | 1 | Decoder is in bypass mode |
| status_o | output | 8 | Status byte: bit 7 polarity, bit 6 toggle, bit 3 window/erase, bit 2 erase toggle, other bits 0 |
| busy_o | output | 1 | Program or erase in progress |
| susp_o | output | 1 | Sector erase suspended |
| rd_status_o | output | 1 | The current read returns status rather than array data |
| done_o | output | 1 | One-cycle completion pulse |
| to_bypass_o | output | 1 | Completion returns to bypass mode |

## Verification
The bench builds the block with one tick per microsecond and with the program, sector and chip exponents set to 3, 0 and 1. That makes a program 8 cycles, the window 50 cycles, a sector erase 1000 cycles per queued command and a chip erase 2000 cycles. With these values every timed path can be run to completion, several times over, within a short run. They also bring into reach a suspend part-way through a running erase, a resume after it, and a second erase that shows the queue was emptied.

// File: rtl/est_pkg.sv
package est_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WIN,
        ST_ERASE,
        ST_CHIP,
        ST_SUSP
    } est_state_e;

    // per-cycle operations on the status byte
    typedef struct packed {
        logic dq7_wr;
        logic dq7_val;
        logic dq7_tgl;
        logic dq6_tgl;
        logic dq3_set;
        logic dq3_clr;
        logic dq2_tgl;
    } st_ctl_t;

    localparam int unsigned US_PER_MS = 1000;

endpackage

// File: rtl/est_timer.sv
module est_timer #(
    parameter int TMR_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             stop,
    input  logic [TMR_W-1:0] load_val,
    output logic [TMR_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [TMR_W-1:0] cnt_q;

    // down counter: a load of T expires T cycles after the loading edge
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (stop)           cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o    = cnt_q;
    assign expire_o = (cnt_q == TMR_W'(1));
endmodule

// File: rtl/est_queue.sv
module est_queue #(
    parameter  int NUM_SECT = 16,
    parameter  int CNT_W    = 8,
    localparam int SW       = $clog2(NUM_SECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add,
    input  logic [SW-1:0]    add_idx,
    input  logic             clear,
    input  logic [SW-1:0]    rd_idx,
    output logic             hit_o,
    output logic [CNT_W-1:0] count_o
);
    logic [NUM_SECT-1:0] map_q;
    logic [CNT_W-1:0]    cnt_q;

    for (genvar g = 0; g < NUM_SECT; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                  map_q[g] <= 1'b0;
            else if (add && add_idx == SW'(g))    map_q[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (add)        cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o   = map_q[rd_idx];
    assign count_o = cnt_q;
endmodule

// File: rtl/est_status.sv
module est_status
    import est_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  st_ctl_t    ctl,
    output logic [7:0] status_o
);
    logic d7_q, d6_q, d3_q, d2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d7_q <= 1'b0;
            d6_q <= 1'b0;
            d3_q <= 1'b0;
            d2_q <= 1'b0;
        end else begin
            if (ctl.dq7_wr)       d7_q <= ctl.dq7_val;
            else if (ctl.dq7_tgl) d7_q <= ~d7_q;
            if (ctl.dq6_tgl)      d6_q <= ~d6_q;
            if (ctl.dq3_set)      d3_q <= 1'b1;
            else if (ctl.dq3_clr) d3_q <= 1'b0;
            if (ctl.dq2_tgl)      d2_q <= ~d2_q;
        end
    end

    assign status_o = {d7_q, d6_q, 2'b00, d3_q, d2_q, 2'b00};
endmodule

// File: rtl/erase_status_timer.sv
module erase_status_timer
    import est_pkg::*;
#(
    parameter  int TICKS_PER_US = 100,
    parameter  int WIN_US       = 50,
    parameter  int PROG_EXP     = 4,
    parameter  int SECT_EXP     = 9,
    parameter  int CHIP_EXP     = 12,
    parameter  int NUM_SECT     = 16,
    parameter  int CNT_W        = 8,
    parameter  int TMR_W        = 40,
    localparam int SW           = $clog2(NUM_SECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_go,
    input  logic          prog_d7,
    input  logic          sect_go,
    input  logic [SW-1:0] sect_idx,
    input  logic          chip_go,
    input  logic          susp_go,
    input  logic          resume_go,
    input  logic          other_wr,
    input  logic          rd_go,
    input  logic [SW-1:0] rd_idx,
    input  logic          bypass_i,
    output logic [7:0]    status_o,
    output logic          busy_o,
    output logic          susp_o,
    output logic          rd_status_o,
    output logic          done_o,
    output logic          to_bypass_o
);
    localparam logic [TMR_W-1:0] WIN_T  = TMR_W'(64'(WIN_US) * 64'(TICKS_PER_US));
    localparam logic [TMR_W-1:0] PROG_T = TMR_W'((64'd1 << PROG_EXP) * 64'(TICKS_PER_US));
    localparam logic [TMR_W-1:0] SECT_T = TMR_W'((64'd1 << SECT_EXP) * 64'(US_PER_MS) * 64'(TICKS_PER_US));
    localparam logic [TMR_W-1:0] CHIP_T = TMR_W'((64'd1 << CHIP_EXP) * 64'(US_PER_MS) * 64'(TICKS_PER_US));

    est_state_e       state_q, state_d;
    st_ctl_t          ctl;
    logic             t_load, t_stop, t_exp;
    logic [TMR_W-1:0] t_val, t_cnt, erase_full;
    logic             q_add, q_clr, q_hit;
    logic [CNT_W-1:0] q_cnt;
    logic             save_en, done_set;
    logic [TMR_W-1:0] save_val, saved_q;
    logic             done_q, byp_q;
    logic             abort;

    est_timer #(.TMR_W(TMR_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .stop(t_stop),
        .load_val(t_val), .cnt_o(t_cnt), .expire_o(t_exp)
    );

    est_queue #(.NUM_SECT(NUM_SECT), .CNT_W(CNT_W)) i_queue (
        .clk(clk), .rst_n(rst_n), .add(q_add), .add_idx(sect_idx),
        .clear(q_clr), .rd_idx(rd_idx), .hit_o(q_hit), .count_o(q_cnt)
    );

    est_status i_status (.clk(clk), .rst_n(rst_n), .ctl(ctl), .status_o(status_o));

    assign erase_full = TMR_W'(q_cnt) * SECT_T;
    assign abort      = other_wr | prog_go | chip_go | resume_go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and per-cycle controls
    always_comb begin
        state_d  = state_q;
        ctl      = '0;
        t_load   = 1'b0;
        t_stop   = 1'b0;
        t_val    = '0;
        q_add    = 1'b0;
        q_clr    = 1'b0;
        save_en  = 1'b0;
        save_val = '0;
        done_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (prog_go) begin
                    t_load = 1'b1; t_val = PROG_T;
                    ctl.dq7_wr = 1'b1; ctl.dq7_val = ~prog_d7;
                    state_d = ST_PROG;
                end else if (sect_go) begin
                    q_add = 1'b1; t_load = 1'b1; t_val = WIN_T;
                    ctl.dq7_wr = 1'b1; ctl.dq3_clr = 1'b1;
                    state_d = ST_WIN;
                end else if (chip_go) begin
                    t_load = 1'b1; t_val = CHIP_T;
                    ctl.dq7_wr = 1'b1;
                    state_d = ST_CHIP;
                end
            end
            ST_PROG: begin
                ctl.dq6_tgl = rd_go;
                if (t_exp) begin
                    ctl.dq7_tgl = 1'b1; done_set = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WIN: begin
                ctl.dq6_tgl = rd_go; ctl.dq2_tgl = rd_go;
                if (susp_go) begin
                    save_en = 1'b1; save_val = erase_full;
                    t_stop = 1'b1; ctl.dq3_clr = 1'b1;
                    state_d = ST_SUSP;
                end else if (abort) begin
                    q_clr = 1'b1; t_stop = 1'b1;
                    state_d = ST_IDLE;
                end else if (sect_go) begin
                    q_add = 1'b1; t_load = 1'b1; t_val = WIN_T;
                end else if (t_exp) begin
                    t_load = 1'b1; t_val = erase_full; ctl.dq3_set = 1'b1;
                    state_d = ST_ERASE;
                end
            end
            ST_ERASE: begin
                ctl.dq6_tgl = rd_go; ctl.dq2_tgl = rd_go;
                if (susp_go) begin
                    save_en = 1'b1;
                    save_val = (t_cnt == '0) ? TMR_W'(1) : t_cnt;
                    t_stop = 1'b1; ctl.dq3_clr = 1'b1;
                    state_d = ST_SUSP;
                end else if (t_exp) begin
                    q_clr = 1'b1; ctl.dq3_clr = 1'b1; ctl.dq7_tgl = 1'b1;
                    done_set = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_CHIP: begin
                ctl.dq6_tgl = rd_go; ctl.dq2_tgl = rd_go;
                if (t_exp) begin
                    ctl.dq7_tgl = 1'b1; done_set = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_SUSP: begin
                ctl.dq2_tgl = rd_go & q_hit;
                if (resume_go) begin
                    t_load = 1'b1; t_val = saved_q;
                    ctl.dq3_set = 1'b1; ctl.dq7_wr = 1'b1;
                    state_d = ST_ERASE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs and saved time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= '0;
            done_q  <= 1'b0;
            byp_q   <= 1'b0;
        end else begin
            if (save_en) saved_q <= save_val;
            done_q <= done_set;
            byp_q  <= done_set & bypass_i;
        end
    end

    assign busy_o      = (state_q == ST_PROG) || (state_q == ST_WIN) ||
                         (state_q == ST_ERASE) || (state_q == ST_CHIP);
    assign susp_o      = (state_q == ST_SUSP);
    assign rd_status_o = rd_go && (busy_o || (susp_o && q_hit));
    assign done_o      = done_q;
    assign to_bypass_o = byp_q;

    a_r2_prog_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && prog_go) |=> (status_o[7] == !$past(prog_d7)));
    a_r3_prog_no_dq2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |=> $stable(status_o[2]));
    a_r4_window_dq3_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WIN) |-> !status_o[3]);
    a_r5_erase_dq3_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE) |-> status_o[3]);
    a_r7_susp_timer_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> (t_cnt == '0));
    a_r8_saved_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && susp_go) |=> (saved_q != '0));
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_IDLE));
endmodule

// File: tb/test_erase_status_timer.sv
`timescale 1ns/1ps
module test_erase_status_timer;
    localparam int NS     = 8;
    localparam int WIN_T  = 50;
    localparam int PROG_T = 8;
    localparam int SECT_T = 1000;
    localparam int CHIP_T = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_go = 0, prog_d7 = 0, sect_go = 0, chip_go = 0;
    logic susp_go = 0, resume_go = 0, other_wr = 0, rd_go = 0, bypass_i = 0;
    logic [2:0] sect_idx = '0, rd_idx = '0;
    logic [7:0] status_o;
    logic busy_o, susp_o, rd_status_o, done_o, to_bypass_o;

    always #2.5 clk = ~clk;

    erase_status_timer #(
        .TICKS_PER_US(1), .WIN_US(50), .PROG_EXP(3), .SECT_EXP(0),
        .CHIP_EXP(1), .NUM_SECT(NS), .CNT_W(8), .TMR_W(40)
    ) i_erase_status_timer (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_d7(prog_d7),
        .sect_go(sect_go), .sect_idx(sect_idx), .chip_go(chip_go),
        .susp_go(susp_go), .resume_go(resume_go), .other_wr(other_wr),
        .rd_go(rd_go), .rd_idx(rd_idx), .bypass_i(bypass_i),
        .status_o(status_o), .busy_o(busy_o), .susp_o(susp_o),
        .rd_status_o(rd_status_o), .done_o(done_o), .to_bypass_o(to_bypass_o)
    );

    // behavioural model: 0 idle, 1 program, 2 window, 3 erase, 4 chip, 5 suspended
    int       ms;
    longint   mleft, msaved;
    int       mcnt;
    bit [NS-1:0] mmap;
    bit [7:0] mst;
    bit       mdone, mbyp, ex;
    int       nvec = 0, nerr = 0;
    string    cur_req = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mleft = 0; msaved = 0; mcnt = 0; mmap = '0;
            mst = 8'h00; mdone = 0; mbyp = 0;
        end else begin
            ex = (mleft == 1);
            if (mleft > 0) mleft--;
            mdone = 0;
            case (ms)
                0: if (prog_go) begin
                       mleft = PROG_T; mst[7] = ~prog_d7; ms = 1;
                   end else if (sect_go) begin
                       mmap[sect_idx] = 1; mcnt++; mleft = WIN_T;
                       mst[7] = 0; mst[3] = 0; ms = 2;
                   end else if (chip_go) begin
                       mleft = CHIP_T; mst[7] = 0; ms = 4;
                   end
                1: begin
                       if (rd_go) mst[6] = ~mst[6];
                       if (ex) begin mst[7] = ~mst[7]; mdone = 1; ms = 0; end
                   end
                2: begin
                       if (rd_go) begin mst[6] = ~mst[6]; mst[2] = ~mst[2]; end
                       if (susp_go) begin
                           msaved = longint'(mcnt) * SECT_T; mleft = 0; mst[3] = 0; ms = 5;
                       end else if (other_wr || prog_go || chip_go || resume_go) begin
                           mmap = '0; mcnt = 0; mleft = 0; ms = 0;
                       end else if (sect_go) begin
                           mmap[sect_idx] = 1; mcnt++; mleft = WIN_T;
                       end else if (ex) begin
                           mleft = longint'(mcnt) * SECT_T; mst[3] = 1; ms = 3;
                       end
                   end
                3: begin
                       if (rd_go) begin mst[6] = ~mst[6]; mst[2] = ~mst[2]; end
                       if (susp_go) begin
                           // time still owed, counting this cycle
                           msaved = (ex ? 1 : mleft + 1);
                           mleft = 0; mst[3] = 0; ms = 5;
                       end else if (ex) begin
                           mmap = '0; mcnt = 0; mst[3] = 0; mst[7] = ~mst[7];
                           mdone = 1; ms = 0;
                       end
                   end
                4: begin
                       if (rd_go) begin mst[6] = ~mst[6]; mst[2] = ~mst[2]; end
                       if (ex) begin mst[7] = ~mst[7]; mdone = 1; ms = 0; end
                   end
                5: begin
                       if (rd_go && mmap[rd_idx]) mst[2] = ~mst[2];
                       if (resume_go) begin
                           mleft = msaved; mst[3] = 1; mst[7] = 0; ms = 3;
                       end
                   end
                default: ms = 0;
            endcase
            mbyp = mdone & bypass_i;
        end
    end

    task automatic check_all();
        bit e_busy, e_susp, e_rds;
        e_busy = (ms >= 1 && ms <= 4);
        e_susp = (ms == 5);
        e_rds  = rd_go && (e_busy || (e_susp && mmap[rd_idx]));
        nvec++;
        if (status_o !== mst || busy_o !== e_busy || susp_o !== e_susp ||
            rd_status_o !== e_rds || done_o !== mdone || to_bypass_o !== mbyp) begin
            nerr++;
            $display("FAIL %s: got st=%02h busy=%b susp=%b rds=%b done=%b byp=%b, expected st=%02h busy=%b susp=%b rds=%b done=%b byp=%b",
                     cur_req, status_o, busy_o, susp_o, rd_status_o, done_o, to_bypass_o,
                     mst, e_busy, e_susp, e_rds, mdone, mbyp);
        end
    endtask

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(negedge clk);
            check_all();
            {prog_go, sect_go, chip_go, susp_go, resume_go, other_wr, rd_go} = '0;
        end
    endtask

    task automatic reads(logic [2:0] idx, int n);
        for (int i = 0; i < n; i++) begin
            rd_go = 1; rd_idx = idx; cyc();
        end
    endtask

    task automatic wait_idle();
        int k = 0;
        while (ms != 0 && k < 6000) begin cyc(); k++; end
        cyc(2);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1"; cyc(3);                          // R1 reset state

        cur_req = "R2"; bypass_i = 1;                    // R2 program, data bit 7 = 1
        prog_go = 1; prog_d7 = 1; cyc();
        cur_req = "R3"; reads(3'd0, 3);                  // R3 bit 6 toggles, bit 2 not
        cur_req = "R2"; wait_idle();
        bypass_i = 0; prog_go = 1; prog_d7 = 0; cyc();   // R2 data bit 7 = 0
        wait_idle();

        cur_req = "R4"; sect_go = 1; sect_idx = 3'd2; cyc(20);   // R4 window
        cur_req = "R3"; reads(3'd4, 2);
        cur_req = "R4"; sect_go = 1; sect_idx = 3'd5; cyc();     // restart window
        cyc(30); sect_go = 1; sect_idx = 3'd5; cyc(); cyc(55);  // duplicate counts again
        cur_req = "R5"; chip_go = 1; cyc(); sect_go = 1; cyc();  // R5 ignored during erase
        resume_go = 1; cyc(); other_wr = 1; cyc(); prog_go = 1; cyc();
        reads(3'd2, 3);
        cur_req = "R11"; bypass_i = 1; wait_idle();      // R11 completion
        bypass_i = 0;

        cur_req = "R4"; sect_go = 1; sect_idx = 3'd1; cyc(10);   // R4 abort
        other_wr = 1; cyc(); cyc(60);
        sect_go = 1; sect_idx = 3'd6; cyc(5); prog_go = 1; cyc(); cyc(60);

        cur_req = "R6"; chip_go = 1; cyc(10);            // R6 chip erase
        reads(3'd0, 2);
        cur_req = "R12"; susp_go = 1; cyc(); sect_go = 1; cyc(); // R12 suspend ignored
        cur_req = "R6"; wait_idle();

        cur_req = "R7"; sect_go = 1; sect_idx = 3'd6; cyc(5);    // R7 suspend in window
        susp_go = 1; cyc(); cyc(5);
        cur_req = "R9"; reads(3'd6, 3); reads(3'd0, 2); // R9 hit and miss
        sect_go = 1; sect_idx = 3'd0; cyc(); cyc(20);
        cur_req = "R10"; resume_go = 1; cyc();           // R10 resume
        wait_idle();

        cur_req = "R8"; sect_go = 1; sect_idx = 3'd1; cyc(60);   // R8 suspend mid-erase
        cyc(300); susp_go = 1; cyc(); cyc(20);
        cur_req = "R9"; reads(3'd1, 2); reads(3'd7, 1);
        cur_req = "R10"; resume_go = 1; cyc();
        wait_idle();

        cur_req = "R12"; resume_go = 1; cyc(); susp_go = 1; cyc(3); // R12 in idle
        prog_go = 1; prog_d7 = 1; cyc(2); susp_go = 1; cyc(); resume_go = 1; cyc();
        wait_idle();

        cur_req = "R11"; sect_go = 1; sect_idx = 3'd3; cyc(4);   // R11 queue was emptied
        susp_go = 1; cyc();
        reads(3'd1, 2); reads(3'd6, 1); reads(3'd3, 1);
        resume_go = 1; cyc();
        wait_idle();

        finish_run();
    end
endmodule